// File: doc/BRIEF.md
# Four-bit carry look-ahead adder

This block adds two 4-bit operands and a carry-in. It does not pass a carry from one bit to the next. Each bit first forms a generate term (both operand bits set) and a propagate term (either operand bit set, inclusive OR). Every internal carry and the carry-out is then a fully expanded two-level sum of products over those terms and the carry-in. No product or sum in these expansions has more than five inputs. Each sum bit is the exclusive OR of the two operand bits and the carry into that bit.

The block also exports a group generate and a group propagate for the four bits. A separate look-ahead unit above it can use these to cascade several copies into a wider adder without rippling between groups.

An optional output register stage supports timing closure. With `REG_OUT = 1` (the default), all four outputs are registered together and appear one clock after their inputs. A synchronous active-high reset clears that stage. With `REG_OUT = 0`, the outputs are combinational and valid in the same cycle as the inputs.

Top module: `cla4_adder`

## Requirements
- R1: `sum` equals the low four bits of `a + b + cin`, treating `a` and `b` as unsigned.
- R2: `cout` equals bit 4 of the 5-bit unsigned result `a + b + cin`.
- R3: `group_g` is 1 exactly when `a + b` (with the carry-in not counted) is 16 or more.
- R4: `group_p` is 1 exactly when, in every bit position, at least one of `a` and `b` has a 1 (that is, `(a | b) == 4'b1111`).
- R5: `cout` always equals `group_g | (group_p & cin)`, with `group_g`, `group_p` and `cout` all taken for the same inputs.
- R6: `group_g` and `group_p` do not depend on `cin`: for equal `a` and `b`, both values of `cin` give the same group outputs.
- R7: Latency depends on `REG_OUT`.
  - With `REG_OUT = 1`, the outputs sampled just after a rising clock edge reflect the inputs present at that edge.
  - With `REG_OUT = 0`, the outputs follow the inputs with no clock.
- R8: With `REG_OUT = 1`, a rising edge with `rst` high sets `sum`, `cout`, `group_g` and `group_p` to 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register stage |
| a | input | 4 | First operand, unsigned |
| b | input | 4 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 4 | Sum bits |
| cout | output | 1 | Carry out of bit 3 |
| group_g | output | 1 | Group generate for a higher-level look-ahead unit |
| group_p | output | 1 | Group propagate for a higher-level look-ahead unit |

## Verification
The bench builds two copies of the block side by side:
- `REG_OUT = 1` (the default), which has the output register and its reset.
- `REG_OUT = 0`, which is purely combinational.

Both copies receive all 512 combinations of `a`, `b` and `cin`. Every carry term and both group terms can therefore be compared against plain integer addition in both latency variants. Reset is applied at the start and again in the middle of the sweep while nonzero operands are held. This shows that the register clears regardless of its data, and that the combinational copy is unaffected by reset.

// File: rtl/cla4_pkg.sv
package cla4_pkg;

    localparam int unsigned NBITS = 4;
    localparam int unsigned NCARRY = NBITS + 1;

    typedef logic [NBITS-1:0] word_t;

    // Per-bit look-ahead terms.
    typedef struct packed {
        word_t gen;
        word_t prop;
    } gp_t;

    // Everything the block presents at its outputs.
    typedef struct packed {
        word_t sum;
        logic  cout;
        logic  grp_g;
        logic  grp_p;
    } result_t;

    localparam int unsigned RESULT_W = $bits(result_t);

    function automatic logic bit_gen(input logic x, input logic y);
        return x & y;
    endfunction

    function automatic logic bit_prop(input logic x, input logic y);
        return x | y;
    endfunction

endpackage

// File: rtl/cla4_gp_cells.sv
module cla4_gp_cells
    import cla4_pkg::*;
(
    input  word_t x,
    input  word_t y,
    output gp_t   terms
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign terms.gen[i]  = bit_gen(x[i], y[i]);
        assign terms.prop[i] = bit_prop(x[i], y[i]);
    end
endmodule

// File: rtl/cla4_lookahead.sv
module cla4_lookahead
    import cla4_pkg::*;
(
    input  gp_t                terms,
    input  logic               c0,
    output logic [NCARRY-1:0]  carry,
    output logic               grp_g,
    output logic               grp_p
);
    word_t g;
    word_t p;

    assign g = terms.gen;
    assign p = terms.prop;

    // Every carry is a flat two-level sum of products over g, p and c0.
    // The widest AND and the widest OR both have five inputs.
    assign carry[0] = c0;

    assign carry[1] = g[0]
                    | (p[0] & c0);

    assign carry[2] = g[1]
                    | (p[1] & g[0])
                    | (p[1] & p[0] & c0);

    assign carry[3] = g[2]
                    | (p[2] & g[1])
                    | (p[2] & p[1] & g[0])
                    | (p[2] & p[1] & p[0] & c0);

    assign carry[4] = g[3]
                    | (p[3] & g[2])
                    | (p[3] & p[2] & g[1])
                    | (p[3] & p[2] & p[1] & g[0])
                    | (p[3] & p[2] & p[1] & p[0] & c0);

    assign grp_g = g[3]
                 | (p[3] & g[2])
                 | (p[3] & p[2] & g[1])
                 | (p[3] & p[2] & p[1] & g[0]);

    assign grp_p = p[3] & p[2] & p[1] & p[0];
endmodule

// File: rtl/cla4_sum.sv
module cla4_sum
    import cla4_pkg::*;
(
    input  word_t              x,
    input  word_t              y,
    input  logic [NCARRY-1:0]  carry,
    output word_t              sum
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign sum[i] = x[i] ^ y[i] ^ carry[i];
    end
endmodule

// File: rtl/cla4_adder.sv
module cla4_adder
    import cla4_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] a,
    input  logic [NBITS-1:0] b,
    input  logic             cin,
    output logic [NBITS-1:0] sum,
    output logic             cout,
    output logic             group_g,
    output logic             group_p
);
    gp_t                terms;
    logic [NCARRY-1:0]  carry;
    word_t              sum_c;
    logic               gg_c;
    logic               gp_c;
    result_t            res_d;
    result_t            res_q;

    cla4_gp_cells u_gp (
        .x     (a),
        .y     (b),
        .terms (terms)
    );

    cla4_lookahead u_la (
        .terms (terms),
        .c0    (cin),
        .carry (carry),
        .grp_g (gg_c),
        .grp_p (gp_c)
    );

    cla4_sum u_sum (
        .x     (a),
        .y     (b),
        .carry (carry),
        .sum   (sum_c)
    );

    assign res_d = '{sum: sum_c, cout: carry[NBITS], grp_g: gg_c, grp_p: gp_c};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign sum     = res_q.sum;
    assign cout    = res_q.cout;
    assign group_g = res_q.grp_g;
    assign group_p = res_q.grp_p;
endmodule

// File: rtl/cla4_adder_checker.sv
module cla4_adder_checker
    import cla4_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [NBITS-1:0] a,
    input logic [NBITS-1:0] b,
    input logic             cin,
    input logic [NBITS-1:0] sum,
    input logic             cout,
    input logic             group_g,
    input logic             group_p
);
    logic [NBITS:0] total;
    logic [NBITS:0] pair;

    assign total = {1'b0, a} + {1'b0, b} + {{NBITS{1'b0}}, cin};
    assign pair  = {1'b0, a} + {1'b0, b};

    // R5 relates outputs to each other; it holds in both variants.
    assert_group_carry_R5: assert property (@(posedge clk) disable iff (rst)
        cout == (group_g | (group_p & (REG_OUT ? $past(cin) : cin))));

    if (REG_OUT) begin : g_reg_chk
        assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
            !rst |=> sum == $past(total[NBITS-1:0]));
        assert_cout_R2: assert property (@(posedge clk) disable iff (rst)
            !rst |=> cout == $past(total[NBITS]));
        assert_group_g_R3: assert property (@(posedge clk) disable iff (rst)
            !rst |=> group_g == $past(pair[NBITS]));
        assert_group_p_R4: assert property (@(posedge clk) disable iff (rst)
            !rst |=> group_p == $past(&(a | b)));
    end else begin : g_comb_chk
        assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
            sum == total[NBITS-1:0]);
        assert_cout_R2: assert property (@(posedge clk) disable iff (rst)
            cout == total[NBITS]);
        assert_group_g_R3: assert property (@(posedge clk) disable iff (rst)
            group_g == pair[NBITS]);
        assert_group_p_R4: assert property (@(posedge clk) disable iff (rst)
            group_p == &(a | b));
    end
endmodule

bind cla4_adder cla4_adder_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .group_g (group_g),
    .group_p (group_p)
);

// File: tb/cla4_adder_test.sv
`timescale 1ns/1ps
module cla4_adder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a   = 4'd0;
    logic [3:0] b   = 4'd0;
    logic       cin = 1'b0;

    logic [3:0] sum_r, sum_c;
    logic       cout_r, cout_c, gg_r, gg_c, gp_r, gp_c;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cla4_adder #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
        .sum(sum_r), .cout(cout_r), .group_g(gg_r), .group_p(gp_r)
    );

    cla4_adder #(.REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
        .sum(sum_c), .cout(cout_c), .group_g(gg_c), .group_p(gp_c)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, a, b, cin, act, exp);
        end
    endtask

    task automatic check_outputs(input bit regd, input int ea, input int eb, input int ec);
        int tot  = ea + eb + ec;
        int ge   = ((ea + eb) >= 16) ? 1 : 0;
        int pe   = ((ea | eb) == 15) ? 1 : 0;
        int s    = regd ? int'(sum_r)  : int'(sum_c);
        int co   = regd ? int'(cout_r) : int'(cout_c);
        int g    = regd ? int'(gg_r)   : int'(gg_c);
        int p    = regd ? int'(gp_r)   : int'(gp_c);
        check(regd ? "R1 R7 reg sum"  : "R1 R7 comb sum",  s,  tot % 16);
        check(regd ? "R2 reg cout"    : "R2 comb cout",    co, tot / 16);
        check(regd ? "R3 R6 reg gg"   : "R3 R6 comb gg",   g,  ge);
        check(regd ? "R4 R6 reg gp"   : "R4 R6 comb gp",   p,  pe);
        check(regd ? "R5 reg relation" : "R5 comb relation", co, g | (p & ec));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R8: reset with nonzero operands clears the registered copy.
        @(negedge clk);
        rst = 1'b1; a = 4'd15; b = 4'd9; cin = 1'b1;
        @(posedge clk); #1;
        check("R8 reset sum",  int'(sum_r),  0);
        check("R8 reset cout", int'(cout_r), 0);
        check("R8 reset gg",   int'(gg_r),   0);
        check("R8 reset gp",   int'(gp_r),   0);
        check_outputs(1'b0, 15, 9, 1);
        @(negedge clk);
        rst = 1'b0;

        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    @(negedge clk);
                    a = 4'(ia); b = 4'(ib); cin = 1'(ic);
                    #1;
                    // R7: combinational copy settles with no clock edge.
                    check_outputs(1'b0, ia, ib, ic);
                    @(posedge clk); #1;
                    check_outputs(1'b1, ia, ib, ic);
                end
            end
            if (ia == 7) begin
                // R8 mid-run: registered copy clears, comb copy unaffected.
                @(negedge clk);
                rst = 1'b1; a = 4'd12; b = 4'd7; cin = 1'b1;
                @(posedge clk); #1;
                check("R8 midrun sum",  int'(sum_r),  0);
                check("R8 midrun cout", int'(cout_r), 0);
                check("R8 midrun gg",   int'(gg_r),   0);
                check("R8 midrun gp",   int'(gp_r),   0);
                check_outputs(1'b0, 12, 7, 1);
                @(negedge clk);
                rst = 1'b0;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule